// File: doc/BRIEF.md
# Smart Card Character Receiver with Parity Error Signaling

This block receives asynchronous characters from the half-duplex I/O line of a smart card. Each character has a low start bit, eight data bits sent least significant bit first, and one parity bit. The block checks each character for even parity. Under the T=0 protocol it can report a failed character back to the card by pulling the shared line low for one bit period, so that the card repeats the character. The same rule applies to every character, including the first character of the answer-to-reset.

The line input has already been synchronized to the clock. The bit period is given as a count of clock cycles. A host sets a handful of control flags, and one set of flags may be wired to several receiver instances. These flags turn off parity checking, turn off error signaling, drop characters that fail, or force every character to count as failed for test purposes. The pull-low output is meant to drive an open-drain pad. While it is high, the line reads low.

Top module: `sc_char_rx`

## Requirements
- R1: A character starts with a high-to-low transition on `line_in` that is still low at mid-bit. The frame is the start bit, then data bits 0 to 7 (LSB first), then the parity bit. Each bit is sampled near its middle, and a bit lasts `etu_cycles` clocks (at least 4). When the character completes, the byte appears on `rx_data` with a one-cycle `rx_valid` pulse.
- R2: With checking on (`cfg_par_off`=0), `err_flag` pulses for one cycle at character completion if the number of ones across the eight data bits and the parity bit is odd. It stays low if that number is even.
- R3: With `cfg_par_off`=1, `err_flag` never rises and `line_pull_low` stays low, whatever the parity bit or the other flags.
- R4: Under T=0 (`proto_t1`=0) with `cfg_brk_off`=0, a failed character makes `line_pull_low` rise about half a bit period after the parity bit ends. It stays high for exactly `etu_cycles` clocks and then falls.
- R5: Under T=1, or with `cfg_brk_off`=1, a failed character raises `err_flag` only. `line_pull_low` stays low, and the byte is still delivered unless R6 applies.
- R6: With `cfg_drop_bad`=1 under T=0, a failed character produces no `rx_valid`, but `err_flag` still pulses. Under T=1 this flag has no effect.
- R7: With `cfg_force_err`=1 and checking on, every character counts as failed, whatever its parity.
- R8: A low glitch shorter than half a bit period does not start a character. The block's own error pulse on the line is not taken as a new start bit.
- R9: During and right after reset, `rx_valid`, `err_flag` and `line_pull_low` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Synchronized level of the card I/O line |
| etu_cycles | input | ETU_W | Bit period in clock cycles |
| proto_t1 | input | 1 | 1 = T=1, 0 = T=0 |
| cfg_par_off | input | 1 | 1 = parity checking disabled |
| cfg_brk_off | input | 1 | 1 = error pulse generation disabled |
| cfg_drop_bad | input | 1 | 1 = drop failed characters under T=0 |
| cfg_force_err | input | 1 | 1 = treat every character as failed |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a delivered byte |
| err_flag | output | 1 | One-cycle parity failure strobe |
| line_pull_low | output | 1 | Request to drive the line low |

## Verification
The bench targets the interactions between flags:
- Disabled checking must mask both a forced error and a real one. A design that checks the flags in the wrong order would signal or drop with checking off.
- Drop has no effect under T=1. A design that ignores the protocol would lose bytes there.
- The pulse is timed against the end of the parity bit and must last exactly one bit period. Counting from the wrong point would shift or stretch it.
- After the pulse, the block must not read its own low level as a start bit. A design that did would deliver a phantom byte.
- A short low glitch on an idle line must be rejected at mid-bit.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    localparam int SC_DATA_BITS = 8;
    localparam int SC_IDX_W     = $clog2(SC_DATA_BITS);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_HOLD
    } rx_state_t;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_GUARD,
        BK_DRIVE
    } bk_state_t;

    typedef struct packed {
        logic par_off;
        logic brk_off;
        logic drop_bad;
        logic force_err;
    } rx_cfg_t;

    typedef struct packed {
        logic [SC_DATA_BITS-1:0] data;
        logic                    valid;
        logic                    err;
    } rx_result_t;

    function automatic logic odd_ones(input logic [SC_DATA_BITS-1:0] d, input logic p);
        return (^d) ^ p;
    endfunction
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
    parameter int ETU_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [ETU_W-1:0] etu,
    output logic             mid_hit,
    output logic             full_hit
);
    typedef logic [ETU_W-1:0] cnt_t;
    localparam cnt_t ONE = cnt_t'(1);

    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign mid_hit  = (cnt_q == ((etu >> 1) - ONE));
    assign full_hit = (cnt_q == (etu - ONE));
endmodule

// File: rtl/sc_break_gen.sv
module sc_break_gen #(
    parameter int ETU_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ETU_W-1:0] etu,
    output logic             busy,
    output logic             pull_low
);
    import sc_rx_pkg::*;

    typedef logic [ETU_W-1:0] cnt_t;
    localparam cnt_t ONE = cnt_t'(1);

    bk_state_t st_q;
    cnt_t      cnt_q;
    logic      last;

    assign last = (cnt_q == (etu - ONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                BK_IDLE: begin
                    cnt_q <= '0;
                    if (start) st_q <= BK_GUARD;
                end
                BK_GUARD: begin
                    if (last) begin
                        st_q  <= BK_DRIVE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                BK_DRIVE: begin
                    if (last) begin
                        st_q  <= BK_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                default: st_q <= BK_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != BK_IDLE);
    assign pull_low = (st_q == BK_DRIVE);
endmodule

// File: rtl/sc_rx_fsm.sv
module sc_rx_fsm (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                line_in,
    input  logic                                mid_hit,
    input  logic                                full_hit,
    input  logic                                proto_t1,
    input  sc_rx_pkg::rx_cfg_t                  cfg,
    input  logic                                brk_busy,
    output logic                                tmr_clr,
    output logic                                brk_start,
    output sc_rx_pkg::rx_result_t               res
);
    import sc_rx_pkg::*;

    rx_state_t               st_q;
    logic                    prev_q;
    logic [SC_IDX_W-1:0]     idx_q;
    logic [SC_DATA_BITS-1:0] shr_q;
    rx_result_t              res_q;

    logic fall;
    logic par_done;
    logic bad;
    logic drop;

    assign fall     = prev_q && !line_in;
    assign par_done = (st_q == RX_PAR) && full_hit;
    assign bad      = !cfg.par_off && (odd_ones(shr_q, line_in) || cfg.force_err);
    assign drop     = bad && !proto_t1 && cfg.drop_bad;
    assign brk_start = par_done && bad && !proto_t1 && !cfg.brk_off;

    always_comb begin
        tmr_clr = 1'b0;
        unique case (st_q)
            RX_IDLE:  tmr_clr = 1'b1;
            RX_START: tmr_clr = mid_hit;
            RX_DATA:  tmr_clr = full_hit;
            RX_PAR:   tmr_clr = full_hit;
            RX_HOLD:  tmr_clr = 1'b1;
            default:  tmr_clr = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_IDLE;
            prev_q <= 1'b1;
            idx_q  <= '0;
            shr_q  <= '0;
            res_q  <= '0;
        end else begin
            prev_q    <= line_in;
            res_q.valid <= 1'b0;
            res_q.err   <= 1'b0;
            unique case (st_q)
                RX_IDLE: begin
                    idx_q <= '0;
                    if (fall) st_q <= RX_START;
                end
                RX_START: begin
                    if (mid_hit) st_q <= line_in ? RX_IDLE : RX_DATA;
                end
                RX_DATA: begin
                    if (full_hit) begin
                        shr_q <= {line_in, shr_q[SC_DATA_BITS-1:1]};
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == SC_IDX_W'(SC_DATA_BITS - 1)) st_q <= RX_PAR;
                    end
                end
                RX_PAR: begin
                    if (full_hit) begin
                        res_q.data  <= shr_q;
                        res_q.valid <= !drop;
                        res_q.err   <= bad;
                        st_q        <= brk_start ? RX_HOLD : RX_IDLE;
                    end
                end
                RX_HOLD: begin
                    if (!brk_busy) st_q <= RX_IDLE;
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    assign res = res_q;
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
    parameter int ETU_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic [ETU_W-1:0] etu_cycles,
    input  logic             proto_t1,
    input  logic             cfg_par_off,
    input  logic             cfg_brk_off,
    input  logic             cfg_drop_bad,
    input  logic             cfg_force_err,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             err_flag,
    output logic             line_pull_low
);
    import sc_rx_pkg::*;

    rx_cfg_t    cfg;
    rx_result_t res;
    logic       tmr_clr, mid_hit, full_hit;
    logic       brk_start, brk_busy;

    assign cfg = '{par_off: cfg_par_off, brk_off: cfg_brk_off,
                   drop_bad: cfg_drop_bad, force_err: cfg_force_err};

    sc_etu_timer #(.ETU_W(ETU_W)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .etu      (etu_cycles),
        .mid_hit  (mid_hit),
        .full_hit (full_hit)
    );

    sc_rx_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .mid_hit   (mid_hit),
        .full_hit  (full_hit),
        .proto_t1  (proto_t1),
        .cfg       (cfg),
        .brk_busy  (brk_busy),
        .tmr_clr   (tmr_clr),
        .brk_start (brk_start),
        .res       (res)
    );

    sc_break_gen #(.ETU_W(ETU_W)) brk_i (
        .clk      (clk),
        .rst      (rst),
        .start    (brk_start),
        .etu      (etu_cycles),
        .busy     (brk_busy),
        .pull_low (line_pull_low)
    );

    assign rx_data  = res.data;
    assign rx_valid = res.valid;
    assign err_flag = res.err;
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk #(
    parameter int ETU_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [ETU_W-1:0] etu_cycles,
    input logic             proto_t1,
    input logic             cfg_par_off,
    input logic             cfg_drop_bad,
    input logic             rx_valid,
    input logic             err_flag,
    input logic             line_pull_low
);
    logic [ETU_W:0] pull_run_q;

    always_ff @(posedge clk) begin
        if (rst || !line_pull_low) pull_run_q <= '0;
        else                       pull_run_q <= pull_run_q + 1'b1;
    end

    // R4: one pulse never lasts longer than one bit period
    a_r4_pull_bounded: assert property (@(posedge clk) disable iff (rst)
        line_pull_low |-> (pull_run_q < {1'b0, etu_cycles}));

    // R1: the byte strobe lasts a single cycle
    a_r1_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R3: no error reported while checking is disabled
    a_r3_off_no_err: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> !$past(cfg_par_off));

    // R6: a failed character is never delivered with drop under T=0
    a_r6_drop_held: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && err_flag) |-> !($past(cfg_drop_bad) && !$past(proto_t1)));

    // R9: outputs quiet in the cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!rx_valid && !err_flag && !line_pull_low));
endmodule

bind sc_char_rx sc_char_rx_chk #(.ETU_W(ETU_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .etu_cycles    (etu_cycles),
    .proto_t1      (proto_t1),
    .cfg_par_off   (cfg_par_off),
    .cfg_drop_bad  (cfg_drop_bad),
    .rx_valid      (rx_valid),
    .err_flag      (err_flag),
    .line_pull_low (line_pull_low)
);

// File: tb/sc_char_rx_tb.sv
module sc_char_rx_tb_top;
    localparam int ETU_W = 12;
    localparam int E     = 16;
    localparam int NV    = 11;

    // {data[8], badpar, t1, off, brkoff, drop, force, exp_valid, exp_err, exp_pull}
    localparam logic [16:0] VEC [NV] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'h7E, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'h0F, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'h12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             card_lvl = 1'b1;
    logic             line_in;
    logic [ETU_W-1:0] etu_cycles = ETU_W'(E);
    logic             proto_t1 = 1'b0;
    logic             cfg_par_off = 1'b0, cfg_brk_off = 1'b0;
    logic             cfg_drop_bad = 1'b0, cfg_force_err = 1'b0;
    logic [7:0]       rx_data;
    logic             rx_valid, err_flag, line_pull_low;

    int total = 0;
    int bad   = 0;

    int n_valid, n_err, n_pull, first_pull;
    logic [7:0] got_data;

    always #2 clk = ~clk;

    assign line_in = card_lvl & ~line_pull_low;

    sc_char_rx #(.ETU_W(ETU_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .line_in       (line_in),
        .etu_cycles    (etu_cycles),
        .proto_t1      (proto_t1),
        .cfg_par_off   (cfg_par_off),
        .cfg_brk_off   (cfg_brk_off),
        .cfg_drop_bad  (cfg_drop_bad),
        .cfg_force_err (cfg_force_err),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .err_flag      (err_flag),
        .line_pull_low (line_pull_low)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(input int n);
        if (rx_valid) begin
            n_valid++;
            got_data = rx_data;
        end
        if (err_flag) n_err++;
        if (line_pull_low) begin
            n_pull++;
            if (first_pull < 0) first_pull = n;
        end
    endtask

    // Drives a full character; bit at index b covers cycles b*E .. b*E+E-1.
    task automatic send_char(input logic [7:0] d, input logic flip);
        logic [9:0] bits;
        bits = {(^d) ^ flip, d, 1'b0};
        n_valid = 0; n_err = 0; n_pull = 0; first_pull = -1; got_data = 8'h00;
        for (int n = 0; n < 14 * E; n++) begin
            @(negedge clk);
            sample(n);
            card_lvl = (n < 10 * E) ? bits[n / E] : 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: quiet outputs in reset
        check("R9 reset valid", int'(rx_valid), 0);
        check("R9 reset err", int'(err_flag), 0);
        check("R9 reset pull", int'(line_pull_low), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            proto_t1      = v[7];
            cfg_par_off   = v[6];
            cfg_brk_off   = v[5];
            cfg_drop_bad  = v[4];
            cfg_force_err = v[3];
            send_char(v[16:9], v[8]);
            // R1 R6 delivery; R2 R3 R7 error; R4 R5 pulse; R8 no phantom start
            check($sformatf("R1/R6 valid count vec%0d", i), n_valid, int'(v[2]));
            check($sformatf("R2/R3/R7 err vec%0d", i), n_err, int'(v[1]));
            check($sformatf("R4/R5 pull cycles vec%0d", i), n_pull, v[0] ? E : 0);
            if (v[2]) check($sformatf("R1 data vec%0d", i), int'(got_data), int'(v[16:9]));
            if (v[0]) begin
                // R4: rise about half a bit after parity end (cycle 10*E)
                total++;
                if (first_pull < 10 * E + E / 2 || first_pull > 10 * E + E / 2 + 3) begin
                    bad++;
                    $display("FAIL R4 pull start actual=%0d expected=%0d..%0d",
                             first_pull, 10 * E + E / 2, 10 * E + E / 2 + 3);
                end
            end
        end

        // R8: short glitch on an idle line is rejected
        proto_t1 = 1'b0; cfg_par_off = 1'b0; cfg_brk_off = 1'b0;
        cfg_drop_bad = 1'b0; cfg_force_err = 1'b0;
        n_valid = 0; n_err = 0; n_pull = 0; first_pull = -1;
        for (int n = 0; n < 14 * E; n++) begin
            @(negedge clk);
            sample(n);
            card_lvl = !(n < E / 4);
        end
        check("R8 glitch valid", n_valid, 0);
        check("R8 glitch err", n_err, 0);

        // R1: back-to-back character after the glitch still received
        send_char(8'h6B, 1'b0);
        check("R1 after glitch valid", n_valid, 1);
        check("R1 after glitch data", int'(got_data), 32'h6B);

        // R9: reset mid-character clears everything
        fork
            send_char(8'hE7, 1'b1);
            begin
                repeat (5 * E) @(negedge clk);
                rst = 1'b1;
                repeat (3) @(negedge clk);
                rst = 1'b0;
            end
        join
        check("R9 reset mid char valid", n_valid, 0);
        check("R9 reset mid char pull", n_pull, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule